// File: doc/BRIEF.md
# Bit-Masked Output Port Register

This block is an 8-bit general-purpose output/input port seen by a simple 32-bit bus slave. It does not sit behind a single word address. The slave decodes a 1024-byte window, and every word in that window reaches the same data register. Address bits [9:2] are not used to pick a word. Instead they form a per-bit select, so a single store can change any chosen subset of output pins and leave the rest untouched. Software needs no read-modify-write, and no interrupt can split an update.

Reads use the same select. A read returns the live pin input levels for the selected bits and zero for all other bits. Software picks the select by adding the offsets of the wanted bits. Bit n has offset 4·2^n: offset 0x004 selects bit 0, offset 0x040 selects bit 4, and offset 0x140 selects bits 4 and 6 together. Reads and writes complete in a single cycle. Decoding of address bits above the window is done outside this block.

Top module: `gpio_masked_port`

## Requirements
- R1: While rst_ni is low, pin_o is all zeros.
- R2: The select is address bits [9:2]. Port bit n is selected when address bit n+2 is 1.
- R3: One cycle after a clock edge with wr_i high, each selected bit of pin_o equals the matching bit of wdata_i[7:0].
- R4: On a write, each bit of pin_o that is not selected keeps its previous value.
- R5: A select with several bits set updates all of those bits in the same write. For example, offset 0x140 updates bits 4 and 6.
- R6: While rd_i is high, rdata_o[7:0] equals pin_i AND the select, in the same cycle.
- R7: rdata_o[31:8] is always 0, and rdata_o is all zeros while rd_i is low.
- R8: Address bits [1:0] and [31:10] have no effect on any access.
- R9: wdata_i[31:8] has no effect on pin_o.
- R10: An all-zero select (offset 0x000) makes a write leave pin_o unchanged and makes a read return 0.
- R11: pin_o does not change on a clock edge where wr_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 32 | Bus byte address; bits [9:2] form the bit select |
| wdata_i | input | 32 | Write data; only bits [7:0] are used |
| wr_i | input | 1 | Write strobe, one access per cycle |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, combinational |
| pin_i | input | 8 | Port input levels |
| pin_o | output | 8 | Port output register |

## Verification
The bench covers several cases:
- An empty select. A design that ignores the select would overwrite every pin.
- Selects that combine several bits. A design that decodes the offset as a word index would update only one bit.
- Writes whose data disagrees with the current pins in the unselected positions. A design that ignores the select would corrupt those pins.
- Address bits [1:0] and [31:10] set. A design that decodes them would break aliasing across the window.
- Garbage in wdata_i[31:8]. A design that uses it could leak it into the port.
- Reads with every input pin high. These expose a design that returns unselected bits or leaves stale data on rdata_o when rd_i is low.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned SEL_LSB = 2;
  localparam int unsigned SEL_MSB = SEL_LSB + PORT_W - 1;
  typedef logic [PORT_W-1:0] port_t;
endpackage

// File: rtl/gpio_sel_decode.sv
module gpio_sel_decode #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned PORT_W  = 8,
  parameter int unsigned SEL_LSB = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [PORT_W-1:0] sel_o
);
  localparam int unsigned SEL_MSB = SEL_LSB + PORT_W - 1;
  // address bits double as a per-bit select
  assign sel_o = addr_i[SEL_MSB:SEL_LSB];
endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg #(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [PORT_W-1:0] sel_i,
  input  logic [PORT_W-1:0] wbits_i,
  output logic [PORT_W-1:0] q_o
);
  for (genvar b = 0; b < PORT_W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                q_o[b] <= 1'b0;
      else if (wr_i && sel_i[b])  q_o[b] <= wbits_i[b];
    end
  end
endmodule

// File: rtl/gpio_read_gather.sv
module gpio_read_gather #(
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned PORT_W = 8
) (
  input  logic              rd_i,
  input  logic [PORT_W-1:0] sel_i,
  input  logic [PORT_W-1:0] pin_i,
  output logic [BUS_W-1:0]  rdata_o
);
  logic [PORT_W-1:0] bits;
  for (genvar b = 0; b < PORT_W; b++) begin : g_bit
    assign bits[b] = rd_i & sel_i[b] & pin_i[b];
  end
  assign rdata_o = {{(BUS_W-PORT_W){1'b0}}, bits};
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
  import gpio_mask_pkg::*;
#(
  parameter int unsigned ADDR_W = BUS_W,
  parameter int unsigned DATA_W = BUS_W,
  parameter int unsigned PW     = PORT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [PW-1:0]     pin_i,
  output logic [PW-1:0]     pin_o
);
  logic [PW-1:0] sel;

  gpio_sel_decode #(.ADDR_W(ADDR_W), .PORT_W(PW), .SEL_LSB(SEL_LSB)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  gpio_out_reg #(.PORT_W(PW)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .sel_i   (sel),
    .wbits_i (wdata_i[PW-1:0]),
    .q_o     (pin_o)
  );

  gpio_read_gather #(.BUS_W(DATA_W), .PORT_W(PW)) u_rd (
    .rd_i    (rd_i),
    .sel_i   (sel),
    .pin_i   (pin_i),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/gpio_masked_port_chk.sv
module gpio_masked_port_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PW     = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [PW-1:0]     pin_i,
  input logic [PW-1:0]     pin_o
);
  localparam int unsigned LSB = 2;
  localparam int unsigned MSB = LSB + PW - 1;

  // R1
  always @(posedge clk_i)
    if (!rst_ni) a_r1_reset_zero: assert (pin_o == '0);

  // R3, R5: selected bits take write data
  a_r3_sel_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((pin_o & $past(addr_i[MSB:LSB])) ==
              ($past(wdata_i[PW-1:0]) & $past(addr_i[MSB:LSB]))));

  // R4
  a_r4_unsel_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((pin_o & ~$past(addr_i[MSB:LSB])) ==
              ($past(pin_o) & ~$past(addr_i[MSB:LSB]))));

  // R10
  a_r10_empty_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[MSB:LSB] == '0) |=> $stable(pin_o));

  // R11
  a_r11_no_wr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(pin_o));

  // R6
  a_r6_read_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> (rdata_o[PW-1:0] == (pin_i & addr_i[MSB:LSB])));

  // R7
  a_r7_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:PW] == '0);
  a_r7_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);
endmodule

bind gpio_masked_port gpio_masked_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PW(PW)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .rdata_o (rdata_o),
  .pin_i   (pin_i),
  .pin_o   (pin_o)
);

// File: tb/tb_gpio_masked_port.sv
`timescale 1ns/1ps
module tb_gpio_masked_port;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [31:0] rdata_o;
  logic [7:0]  pin_i = '0;
  logic [7:0]  pin_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] model = '0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  gpio_masked_port dut (.*);

  function automatic logic [7:0] exp_write(logic [7:0] cur, logic [31:0] a, logic [31:0] d);
    logic [7:0] s = a[9:2];
    return (cur & ~s) | (d[7:0] & s);
  endfunction

  function automatic logic [31:0] exp_read(logic r, logic [31:0] a, logic [7:0] p);
    return r ? {24'd0, p & a[9:2]} : 32'd0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample at the next negedge after the write edge
  task automatic do_write(string req, logic [31:0] a, logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1; rd_i = 1'b0;
    @(negedge clk_i);
    wr_i = 1'b0;
    model = exp_write(model, a, d);
    check(req, {24'd0, pin_o}, {24'd0, model});
  endtask

  task automatic do_read(string req, logic r, logic [31:0] a, logic [7:0] p);
    @(negedge clk_i);
    addr_i = a; pin_i = p; rd_i = r; wr_i = 1'b0;
    #1;
    check(req, rdata_o, exp_read(r, a, p));
  endtask

  initial begin
    #5000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check("R1 reset", {24'd0, pin_o}, 32'd0);
    rst_ni = 1'b1;

    do_write("R2 bit0 offset 0x004", 32'h0000_0004, 32'hFF);
    do_write("R3 all bits 0x3FC", 32'h0000_03FC, 32'hA5);
    do_write("R4 unselected kept", 32'h0000_0040, 32'h00);
    do_write("R5 combined 0x140", 32'h0000_0140, 32'hFF);
    do_write("R10 empty select write", 32'h0000_0000, 32'h5A);
    do_write("R8 addr low and high bits ignored", 32'hFFFF_FC03 | 32'h0000_0008, 32'h00);
    do_write("R9 upper wdata ignored", 32'h0000_0200, 32'hFFFF_FF00);

    // R11: edges with wr_i low leave pin_o alone
    @(negedge clk_i);
    addr_i = 32'h3FC; wdata_i = 32'h0; wr_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R11 no write hold", {24'd0, pin_o}, {24'd0, model});

    do_read("R6 read selected pins", 1'b1, 32'h0000_0140, 8'hFF);
    do_read("R10 empty select read", 1'b1, 32'h0000_0000, 8'hFF);
    do_read("R7 idle read zero", 1'b0, 32'h0000_03FC, 8'hFF);
    do_read("R8 read aliasing", 1'b1, 32'hABCD_E7FF, 8'h3C);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] a = $urandom;
      logic [31:0] d = $urandom;
      if ($urandom_range(1, 0) == 1) do_write("R3 R4 random write", a, d);
      else do_read("R6 R7 random read", ($urandom_range(3, 0) != 0), a, d[15:8]);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule